// File: doc/BRIEF.md
# Rolling Event Log Recorder

This block keeps a short rolling history of monitor snapshots and freezes it when a fault occurs. A monitor multiplexer presents one sample per slot. Slots 0 to N_INPUTS-1 carry the converted inputs, and slot N_INPUTS carries the status word. One full pass over every slot forms one record. Records go into a ring of DEPTH entries, and the oldest entry is overwritten as the ring wraps.

When a fault trigger is accepted, the recorder notes which slot was in conversion. It keeps recording until the current pass is complete, then stops writing. Once the die is cool enough, it streams the frozen log byte by byte to a nonvolatile store over a valid/ready handshake. After the copy it serves the same fixed-length image on a read port, with the newest record first.

After reset, logging can be held off if an earlier log was found in the store. A partial earlier log holds logging off until a second clear command arrives.

Top module: `event_log_recorder`

## Requirements
- R1: While recording, every valid sample is written at its slot position in the current ring record. The status slot N_INPUTS closes the record, and the ring keeps the DEPTH (6) most recent complete records.
- R2: The log image is LOG_BYTES = 2 + DEPTH*(N_INPUTS+1) bytes (32 at defaults). Byte 0 is the trigger slot index. Byte 1 is the number of complete records held, saturating at DEPTH. Records follow newest first, each as slots 0..N_INPUTS in slot order.
- R3: After an accepted trigger, samples up to and including the next status slot are still recorded, and later samples are not. `ring_frozen` rises the cycle after that status sample, or the cycle after the trigger if the trigger comes with the status sample.
- R4: Header byte 0 holds the slot index presented together with the accepted trigger.
- R5: The copy does not start while the die is hot. Hot is set when `die_temp` > 130 and cleared only when `die_temp` < 125, so a reading of 125 to 130 keeps the previous state.
- R6: Copy-out presents bytes at addresses 0..LOG_BYTES-1 in order. `nv_valid`, `nv_addr` and `nv_data` hold steady until `nv_ready`. `nv_done` rises after the last byte is accepted and stays high.
- R7: `log_count` is LOG_BYTES while a copied log is held and 0 otherwise. `rd_data` returns the image byte at `rd_addr` one cycle later, and 0 for addresses at or beyond LOG_BYTES.
- R8: If `boot_log_found` is high during reset, `valid_log` is 1 and triggers are ignored until `clr_faults`, which clears `valid_log`.
- R9: If `boot_mem_fault` is also high during reset, `partial_log` is 1 and triggers stay ignored until `clr_log` is also given, which clears `partial_log`.
- R10: A trigger that arrives while finishing, waiting, copying or holding a log is ignored. The header and the copied image are unchanged.
- R11: `clr_faults` while a log is held drops it. `log_count` returns to 0, recording resumes, and the record count restarts from 0.
- R12: After reset, `ring_frozen`, `nv_valid`, `nv_done`, `log_count`, `valid_log` and `partial_log` are 0 when no earlier log is reported.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| boot_log_found | input | 1 | Store reports an earlier log; sampled during reset |
| boot_mem_fault | input | 1 | Earlier log is partial; sampled during reset |
| smp_valid | input | 1 | Sample present this cycle |
| smp_idx | input | IDX_W (3) | Slot of the sample; N_INPUTS is the status slot |
| smp_data | input | 8 | Sample or status byte |
| fault_trig | input | 1 | Fault trigger pulse |
| die_temp | input | TEMP_W (8) | Die temperature in degrees C |
| clr_faults | input | 1 | Clear-faults command pulse |
| clr_log | input | 1 | Clear-log command pulse |
| nv_valid | output | 1 | Copy byte offered to the store |
| nv_addr | output | ADDR_W (6) | Byte address within the image |
| nv_data | output | 8 | Byte value |
| nv_ready | input | 1 | Store accepts the byte |
| nv_done | output | 1 | Copy finished |
| rd_addr | input | ADDR_W (6) | Readout byte address |
| rd_data | output | 8 | Readout byte, one cycle after the address |
| log_count | output | CNT_W (6) | Image length, or 0 without a log |
| ring_frozen | output | 1 | Ring no longer written |
| valid_log | output | 1 | Earlier log reported at reset, not yet cleared |
| partial_log | output | 1 | Earlier log partial, not yet cleared |

## Verification
A fault trigger and the status sample that closes a pass can fall in the same cycle. The recorder must then freeze right away instead of waiting for another full pass. The stimulus table fires the trigger on the status slot in one scenario and on interior slots in the others. The result is judged from the copied and read-back image: header byte 0 must equal the trigger slot, the newest record must be the pass that held the trigger, and the pass fed after it must be absent. A second trigger on the next sample and another during copy-out are also mixed in, and they must leave the image unchanged.

// File: rtl/elog_pkg.sv
package elog_pkg;
  localparam int HDR_BYTES = 2;

  typedef enum logic [2:0] {
    ST_REC,
    ST_FINISH,
    ST_WAIT_T,
    ST_COPY,
    ST_DONE
  } elog_state_t;
endpackage

// File: rtl/elog_ring_ram.sv
module elog_ring_ram #(
  parameter int WORDS = 30,
  parameter int AW    = 5
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [7:0]    wdata,
  input  logic [AW-1:0] raddr,
  output logic [7:0]    rdata
);
  logic [7:0] mem [WORDS];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/elog_temp_gate.sv
module elog_temp_gate #(
  parameter int TEMP_W = 8,
  parameter int HOT_C  = 130,
  parameter int COOL_C = 125
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [TEMP_W-1:0] temp,
  output logic              hot
);
  localparam logic [TEMP_W-1:0] HOT_T  = TEMP_W'(HOT_C);
  localparam logic [TEMP_W-1:0] COOL_T = TEMP_W'(COOL_C);

  always_ff @(posedge clk) begin
    if (rst)                hot <= 1'b0;
    else if (temp > HOT_T)  hot <= 1'b1;
    else if (temp < COOL_T) hot <= 1'b0;
  end
endmodule

// File: rtl/elog_addr_map.sv
module elog_addr_map #(
  parameter int N_INPUTS = 4,
  parameter int DEPTH    = 6,
  parameter int ADDR_W   = 6,
  parameter int PTR_W    = 3,
  parameter int RAM_AW   = 5
) (
  input  logic [ADDR_W-1:0] byte_addr,
  input  logic [PTR_W-1:0]  wr_ptr,
  output logic              hdr_sel,
  output logic              hdr_hi,
  output logic              oob,
  output logic [RAM_AW-1:0] ram_addr
);
  import elog_pkg::*;
  localparam int REC       = N_INPUTS + 1;
  localparam int LOG_BYTES = HDR_BYTES + DEPTH * REC;

  always_comb begin
    int off, r, b, phys;
    hdr_sel  = 1'b0;
    hdr_hi   = 1'b0;
    oob      = 1'b0;
    ram_addr = '0;
    off = 0; r = 0; b = 0; phys = 0;
    if (int'(byte_addr) >= LOG_BYTES) begin
      oob = 1'b1;
    end else if (int'(byte_addr) < HDR_BYTES) begin
      hdr_sel = 1'b1;
      hdr_hi  = byte_addr[0];
    end else begin
      off  = int'(byte_addr) - HDR_BYTES;
      r    = off / REC;
      b    = off % REC;
      // newest complete record sits just behind the write pointer
      phys = (int'(wr_ptr) + DEPTH - 1 - r) % DEPTH;
      ram_addr = RAM_AW'(phys * REC + b);
    end
  end
endmodule

// File: rtl/event_log_recorder.sv
module event_log_recorder
  import elog_pkg::*;
#(
  parameter int N_INPUTS  = 4,
  parameter int DEPTH     = 6,
  parameter int TEMP_W    = 8,
  parameter int HOT_C     = 130,
  parameter int COOL_C    = 125,
  localparam int REC_BYTES = N_INPUTS + 1,
  localparam int RAM_WORDS = DEPTH * REC_BYTES,
  localparam int LOG_BYTES = HDR_BYTES + RAM_WORDS,
  localparam int IDX_W     = $clog2(REC_BYTES),
  localparam int ADDR_W    = $clog2(LOG_BYTES) + 1,
  localparam int CNT_W     = $clog2(LOG_BYTES + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              boot_log_found,
  input  logic              boot_mem_fault,
  input  logic              smp_valid,
  input  logic [IDX_W-1:0]  smp_idx,
  input  logic [7:0]        smp_data,
  input  logic              fault_trig,
  input  logic [TEMP_W-1:0] die_temp,
  input  logic              clr_faults,
  input  logic              clr_log,
  output logic              nv_valid,
  output logic [ADDR_W-1:0] nv_addr,
  output logic [7:0]        nv_data,
  input  logic              nv_ready,
  output logic              nv_done,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [7:0]        rd_data,
  output logic [CNT_W-1:0]  log_count,
  output logic              ring_frozen,
  output logic              valid_log,
  output logic              partial_log
);
  localparam int RAM_AW = $clog2(RAM_WORDS);
  localparam int PTR_W  = $clog2(DEPTH);
  localparam int FILL_W = $clog2(DEPTH + 1);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(N_INPUTS);

  elog_state_t       st;
  logic [IDX_W-1:0]  nxt_idx, hdr_idx;
  logic [PTR_W-1:0]  wr_ptr;
  logic [FILL_W-1:0] fill;
  logic              block_a, block_b;
  logic [ADDR_W-1:0] cpy_ptr;
  logic              cpy_fetch;
  logic              hot;

  logic              smp_last, recording, ram_we, log_en, accept_trig;
  logic [RAM_AW-1:0] waddr, raddr;
  logic [ADDR_W-1:0] map_addr;
  logic              m_hdr, m_hi, m_oob;
  logic              hdr_q, hi_q, oob_q;
  logic [7:0]        ram_q, byte_out;

  assign smp_last    = smp_valid && (smp_idx == LAST_IDX);
  assign recording   = (st == ST_REC) || (st == ST_FINISH);
  assign ram_we      = smp_valid && recording;
  assign waddr       = RAM_AW'(int'(wr_ptr) * REC_BYTES + int'(smp_idx));
  assign log_en      = !block_a && !block_b;
  assign accept_trig = fault_trig && (st == ST_REC) && log_en;
  assign map_addr    = (st == ST_DONE) ? rd_addr : cpy_ptr;

  elog_temp_gate #(.TEMP_W(TEMP_W), .HOT_C(HOT_C), .COOL_C(COOL_C)) u_temp (
    .clk(clk), .rst(rst), .temp(die_temp), .hot(hot)
  );

  elog_addr_map #(
    .N_INPUTS(N_INPUTS), .DEPTH(DEPTH), .ADDR_W(ADDR_W),
    .PTR_W(PTR_W), .RAM_AW(RAM_AW)
  ) u_map (
    .byte_addr(map_addr), .wr_ptr(wr_ptr),
    .hdr_sel(m_hdr), .hdr_hi(m_hi), .oob(m_oob), .ram_addr(raddr)
  );

  elog_ring_ram #(.WORDS(RAM_WORDS), .AW(RAM_AW)) u_ram (
    .clk(clk), .we(ram_we), .waddr(waddr), .wdata(smp_data),
    .raddr(raddr), .rdata(ram_q)
  );

  // byte source select, aligned with the registered RAM read
  always_ff @(posedge clk) begin
    if (rst) begin
      hdr_q <= 1'b0;
      hi_q  <= 1'b0;
      oob_q <= 1'b1;
    end else begin
      hdr_q <= m_hdr;
      hi_q  <= m_hi;
      oob_q <= m_oob;
    end
  end

  always_comb begin
    if (oob_q)      byte_out = 8'h00;
    else if (hdr_q) byte_out = hi_q ? 8'(fill) : 8'(hdr_idx);
    else            byte_out = ram_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= ST_REC;
      nxt_idx   <= '0;
      hdr_idx   <= '0;
      wr_ptr    <= '0;
      fill      <= '0;
      block_a   <= boot_log_found;
      block_b   <= boot_log_found && boot_mem_fault;
      cpy_ptr   <= '0;
      cpy_fetch <= 1'b1;
    end else begin
      if (clr_faults) block_a <= 1'b0;
      if (clr_log)    block_b <= 1'b0;

      if (ram_we) begin
        nxt_idx <= smp_last ? '0 : smp_idx + 1'b1;
        if (smp_last) begin
          wr_ptr <= (wr_ptr == PTR_W'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
          if (fill != FILL_W'(DEPTH)) fill <= fill + 1'b1;
        end
      end

      unique case (st)
        ST_REC: if (accept_trig) begin
          hdr_idx <= nxt_idx;
          st      <= smp_last ? ST_WAIT_T : ST_FINISH;
        end
        ST_FINISH: if (smp_last) st <= ST_WAIT_T;
        ST_WAIT_T: if (!hot) begin
          st        <= ST_COPY;
          cpy_ptr   <= '0;
          cpy_fetch <= 1'b1;
        end
        ST_COPY: begin
          if (cpy_fetch) begin
            cpy_fetch <= 1'b0;
          end else if (nv_ready) begin
            if (cpy_ptr == ADDR_W'(LOG_BYTES - 1)) begin
              st <= ST_DONE;
            end else begin
              cpy_ptr   <= cpy_ptr + 1'b1;
              cpy_fetch <= 1'b1;
            end
          end
        end
        ST_DONE: if (clr_faults) begin
          st   <= ST_REC;
          fill <= '0;
        end
        default: st <= ST_REC;
      endcase
    end
  end

  assign nv_valid    = (st == ST_COPY) && !cpy_fetch;
  assign nv_addr     = cpy_ptr;
  assign nv_data     = byte_out;
  assign nv_done     = (st == ST_DONE);
  assign rd_data     = byte_out;
  assign log_count   = (st == ST_DONE) ? CNT_W'(LOG_BYTES) : '0;
  assign ring_frozen = (st == ST_WAIT_T) || (st == ST_COPY) || (st == ST_DONE);
  assign valid_log   = block_a;
  assign partial_log = block_b;
endmodule

// File: rtl/elog_checker.sv
module elog_checker
  import elog_pkg::*;
#(
  parameter int LOG_BYTES = 32,
  parameter int LAST_IDX  = 4,
  parameter int IDX_W     = 3,
  parameter int ADDR_W    = 6
) (
  input logic              clk,
  input logic              rst,
  input elog_state_t       st,
  input logic              hot,
  input logic              log_en,
  input logic              fault_trig,
  input logic              smp_valid,
  input logic [IDX_W-1:0]  smp_idx,
  input logic              nv_valid,
  input logic              nv_ready,
  input logic [ADDR_W-1:0] nv_addr,
  input logic [7:0]        nv_data,
  input logic              nv_done
);
  assert_hold_R6: assert property (@(posedge clk) disable iff (rst)
    nv_valid && !nv_ready |=> nv_valid && $stable(nv_addr) && $stable(nv_data));

  assert_addr_range_R6: assert property (@(posedge clk) disable iff (rst)
    nv_valid |-> nv_addr < ADDR_W'(LOG_BYTES));

  assert_done_after_last_R6: assert property (@(posedge clk) disable iff (rst)
    $rose(nv_done) |-> $past(nv_valid && nv_ready && nv_addr == ADDR_W'(LOG_BYTES - 1)));

  assert_hot_hold_R5: assert property (@(posedge clk) disable iff (rst)
    st == ST_WAIT_T && hot |=> st == ST_WAIT_T);

  assert_finish_end_R3: assert property (@(posedge clk) disable iff (rst)
    st == ST_FINISH && smp_valid && smp_idx == IDX_W'(LAST_IDX) |=> st == ST_WAIT_T);

  assert_blocked_R8: assert property (@(posedge clk) disable iff (rst)
    st == ST_REC && fault_trig && !log_en |=> st == ST_REC);

  assert_retrig_R10: assert property (@(posedge clk) disable iff (rst)
    st == ST_COPY && fault_trig |=> st == ST_COPY || st == ST_DONE);
endmodule

bind event_log_recorder elog_checker #(
  .LOG_BYTES(LOG_BYTES), .LAST_IDX(N_INPUTS), .IDX_W(IDX_W), .ADDR_W(ADDR_W)
) u_chk (
  .clk(clk), .rst(rst), .st(st), .hot(hot), .log_en(log_en),
  .fault_trig(fault_trig), .smp_valid(smp_valid), .smp_idx(smp_idx),
  .nv_valid(nv_valid), .nv_ready(nv_ready), .nv_addr(nv_addr),
  .nv_data(nv_data), .nv_done(nv_done)
);

// File: tb/sim_event_log_recorder.sv
`timescale 1ns/100ps
module sim_event_log_recorder;
  localparam int N     = 4;
  localparam int DEPTH = 6;
  localparam int REC   = N + 1;
  localparam int LOGB  = 2 + DEPTH * REC;
  localparam int IDX_W = $clog2(REC);
  localparam int ADDR_W = $clog2(LOGB) + 1;
  localparam int CNT_W  = $clog2(LOGB + 1);

  typedef struct packed {
    logic [3:0] pre;
    logic [2:0] slot;
    logic       hot;
    logic       retrig;
    logic [1:0] rmode;
  } scen_t;

  localparam int NSCEN = 5;
  localparam scen_t SCEN [NSCEN] = '{
    '{4'd6,  3'd0, 1'b0, 1'b0, 2'd0},
    '{4'd7,  3'd2, 1'b1, 1'b0, 2'd1},
    '{4'd9,  3'd4, 1'b0, 1'b1, 2'd2},
    '{4'd5,  3'd3, 1'b0, 1'b0, 2'd1},
    '{4'd12, 3'd1, 1'b1, 1'b1, 2'd0}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic boot_log_found = 1'b0, boot_mem_fault = 1'b0;
  logic smp_valid = 1'b0;
  logic [IDX_W-1:0] smp_idx = '0;
  logic [7:0] smp_data = '0;
  logic fault_trig = 1'b0;
  logic [7:0] die_temp = 8'd60;
  logic clr_faults = 1'b0, clr_log = 1'b0;
  logic nv_valid, nv_done, nv_ready = 1'b0;
  logic [ADDR_W-1:0] nv_addr, rd_addr = '0;
  logic [7:0] nv_data, rd_data;
  logic [CNT_W-1:0] log_count;
  logic ring_frozen, valid_log, partial_log;

  int checks = 0, errors = 0;
  logic [7:0] got [LOGB];
  int ngot;

  always #2.5 clk = ~clk;

  event_log_recorder u0 (
    .clk(clk), .rst(rst), .boot_log_found(boot_log_found),
    .boot_mem_fault(boot_mem_fault), .smp_valid(smp_valid), .smp_idx(smp_idx),
    .smp_data(smp_data), .fault_trig(fault_trig), .die_temp(die_temp),
    .clr_faults(clr_faults), .clr_log(clr_log), .nv_valid(nv_valid),
    .nv_addr(nv_addr), .nv_data(nv_data), .nv_ready(nv_ready), .nv_done(nv_done),
    .rd_addr(rd_addr), .rd_data(rd_data), .log_count(log_count),
    .ring_frozen(ring_frozen), .valid_log(valid_log), .partial_log(partial_log)
  );

  function automatic logic [7:0] sval(input int c, input int i);
    if (i == N) return 8'(8'hA0 + c);
    return 8'(c * 16 + i * 3 + 1);
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset(input logic boot, input logic mem);
    @(negedge clk);
    rst = 1'b1; boot_log_found = boot; boot_mem_fault = mem;
    smp_valid = 1'b0; fault_trig = 1'b0; clr_faults = 1'b0; clr_log = 1'b0;
    nv_ready = 1'b0; die_temp = 8'd60;
    repeat (3) @(negedge clk);
    rst = 1'b0; boot_log_found = 1'b0; boot_mem_fault = 1'b0;
  endtask

  task automatic pulse_cmd(input bit faults, input bit logc);
    @(negedge clk);
    clr_faults = faults; clr_log = logc;
    @(negedge clk);
    clr_faults = 1'b0; clr_log = 1'b0;
  endtask

  // one full pass of all slots; trigger on slot 'slot' (and the next when retrig)
  task automatic feed_cycle(input int c, input int slot, input bit retrig);
    for (int i = 0; i <= N; i++) begin
      @(negedge clk);
      smp_valid = 1'b1; smp_idx = IDX_W'(i); smp_data = sval(c, i);
      fault_trig = (i == slot) || (retrig && slot >= 0 && i == slot + 1);
      if (c % 2 == 1) begin
        @(negedge clk);
        smp_valid = 1'b0; fault_trig = 1'b0;
      end
    end
    @(negedge clk);
    smp_valid = 1'b0; fault_trig = 1'b0;
  endtask

  task automatic collect_copy(input int rmode, input bit retrig);
    int cnt;
    ngot = 0; cnt = 0;
    while (!nv_done && cnt < 3000) begin
      @(negedge clk);
      case (rmode)
        1: nv_ready = (cnt % 3 != 0);
        2: nv_ready = (cnt % 2 == 1);
        default: nv_ready = 1'b1;
      endcase
      fault_trig = retrig && (ngot == 5);
      if (nv_valid && nv_ready && ngot < LOGB) begin
        chk(int'(nv_addr) == ngot, "R6 copy address order", int'(nv_addr), ngot);
        got[ngot] = nv_data;
        ngot++;
      end
      cnt++;
    end
    @(negedge clk);
    nv_ready = 1'b0; fault_trig = 1'b0;
    chk(nv_done == 1'b1, "R6 nv_done after copy", int'(nv_done), 1);
    chk(ngot == LOGB, "R6 copied byte count", ngot, LOGB);
  endtask

  function automatic logic [7:0] exp_byte(input int a, input int k, input int slot);
    int r, b, fillv;
    fillv = (k < DEPTH) ? k : DEPTH;
    if (a == 0) return 8'(slot);
    if (a == 1) return 8'(fillv);
    r = (a - 2) / REC;
    b = (a - 2) % REC;
    return sval(k - 1 - r, b);
  endfunction

  task automatic read_byte(input int a, output logic [7:0] v);
    @(negedge clk);
    rd_addr = ADDR_W'(a);
    @(negedge clk);
    v = rd_data;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] v;
    int seen;

    // R12: reset state
    do_reset(1'b0, 1'b0);
    @(negedge clk);
    chk(log_count == 0, "R12 log_count after reset", int'(log_count), 0);
    chk(!nv_valid && !nv_done, "R12 copy idle after reset", int'({nv_valid, nv_done}), 0);
    chk(!ring_frozen, "R12 ring_frozen after reset", int'(ring_frozen), 0);
    chk(!valid_log && !partial_log, "R12 boot flags after reset",
        int'({valid_log, partial_log}), 0);

    // stimulus table
    for (int s = 0; s < NSCEN; s++) begin
      int k;
      do_reset(1'b0, 1'b0);
      die_temp = SCEN[s].hot ? 8'd135 : 8'd60;
      for (int c = 0; c < int'(SCEN[s].pre); c++) feed_cycle(c, -1, 1'b0);
      feed_cycle(int'(SCEN[s].pre), int'(SCEN[s].slot), SCEN[s].retrig);
      // R3: frozen right after the trigger pass closes
      chk(ring_frozen == 1'b1, "R3 frozen after pass completes", int'(ring_frozen), 1);
      feed_cycle(int'(SCEN[s].pre) + 1, -1, 1'b0);
      k = int'(SCEN[s].pre) + 1;
      if (SCEN[s].hot) begin
        seen = 0;
        repeat (20) begin @(negedge clk); if (nv_valid || nv_done) seen++; end
        chk(seen == 0, "R5 no copy while hot", seen, 0);
        die_temp = 8'd127;
        repeat (10) begin @(negedge clk); if (nv_valid || nv_done) seen++; end
        chk(seen == 0, "R5 hysteresis band keeps hold", seen, 0);
        chk(log_count == 0, "R7 no count before copy", int'(log_count), 0);
        die_temp = 8'd110;
      end
      collect_copy(int'(SCEN[s].rmode), SCEN[s].retrig);
      chk(got[0] == 8'(SCEN[s].slot), "R4 header trigger slot (R10 retrig)",
          int'(got[0]), int'(SCEN[s].slot));
      for (int a = 1; a < LOGB; a++)
        chk(got[a] == exp_byte(a, k, int'(SCEN[s].slot)), "R1 R2 copied image byte",
            int'(got[a]), int'(exp_byte(a, k, int'(SCEN[s].slot))));
      chk(int'(log_count) == LOGB, "R7 log_count with log", int'(log_count), LOGB);
      for (int a = 0; a < LOGB; a += 3) begin
        read_byte(a, v);
        chk(v == exp_byte(a, k, int'(SCEN[s].slot)), "R7 readout byte",
            int'(v), int'(exp_byte(a, k, int'(SCEN[s].slot))));
      end
    end

    // R7: out-of-range readout
    read_byte(LOGB, v);
    chk(v == 8'h00, "R7 readout beyond image", int'(v), 0);
    read_byte(LOGB + 7, v);
    chk(v == 8'h00, "R7 readout far beyond image", int'(v), 0);

    // R11: clear drops the log, recording restarts with fresh count
    pulse_cmd(1'b1, 1'b0);
    chk(log_count == 0, "R11 count cleared", int'(log_count), 0);
    chk(!ring_frozen, "R11 recording resumed", int'(ring_frozen), 0);
    die_temp = 8'd50;
    feed_cycle(20, -1, 1'b0);
    feed_cycle(21, -1, 1'b0);
    feed_cycle(22, 1, 1'b0);
    collect_copy(0, 1'b0);
    chk(got[1] == 8'd3, "R11 record count restarts", int'(got[1]), 3);
    chk(got[2] == sval(22, 0), "R11 newest record after clear", int'(got[2]),
        int'(sval(22, 0)));

    // R8: earlier log blocks triggers until clear-faults
    do_reset(1'b1, 1'b0);
    @(negedge clk);
    chk(valid_log == 1'b1, "R8 valid_log set at boot", int'(valid_log), 1);
    feed_cycle(0, 2, 1'b0);
    chk(!ring_frozen, "R8 trigger ignored while blocked", int'(ring_frozen), 0);
    pulse_cmd(1'b1, 1'b0);
    chk(valid_log == 1'b0, "R8 valid_log cleared", int'(valid_log), 1'b0);
    feed_cycle(1, 2, 1'b0);
    chk(ring_frozen == 1'b1, "R8 trigger accepted after clear", int'(ring_frozen), 1);

    // R9: partial log needs both clears
    do_reset(1'b1, 1'b1);
    @(negedge clk);
    chk(partial_log == 1'b1, "R9 partial_log set at boot", int'(partial_log), 1);
    pulse_cmd(1'b1, 1'b0);
    chk(!valid_log && partial_log, "R9 clear-faults alone keeps partial",
        int'({valid_log, partial_log}), 1);
    feed_cycle(0, 0, 1'b0);
    chk(!ring_frozen, "R9 trigger still ignored", int'(ring_frozen), 0);
    pulse_cmd(1'b0, 1'b1);
    chk(partial_log == 1'b0, "R9 partial cleared", int'(partial_log), 0);
    feed_cycle(1, 0, 1'b0);
    chk(ring_frozen == 1'b1, "R9 trigger accepted after both clears", int'(ring_frozen), 1);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule